// File: doc/BRIEF.md
# Framed Test-Packet Stream Checker

This block sits at the receiving end of a byte-wide framed stream that a matching test-pattern source produces, and decides packet by packet whether the data came through intact. Every packet has a fixed shape. Four header bytes give the packet length and four more give a running sequence number, both least significant byte first. A counting payload follows, in which each byte holds the low eight bits of its own position. Four checksum bytes close the packet, most significant byte first.

The stream carries start-of-frame and end-of-frame flags, a valid strobe from the sender and a ready strobe from the block. Ready is tied high, so the block takes every byte that is offered. It keeps its own byte position, runs a CRC-32 over the covered bytes and compares each field against what it expects. Each failure kind sets its own sticky flag. At the last checksum byte it issues a one-cycle pass or fail pulse and steps a good-packet or bad-packet counter. A synchronous clear puts the block back into its reset state between test runs.

Top module: `pkt_stream_checker`

## Requirements
- R1: A byte is taken only on a rising edge where `in_valid` is 1. On cycles with `in_valid` at 0, the data and flag inputs are ignored: no position advance, no pulse, no flag change and no count change.
- R2: Bytes at positions 0..3 form a 32-bit length, byte 0 least significant. If it differs from `PKT_LEN`, `err_len` is set.
- R3: Bytes at positions 4..7 form a 32-bit sequence number, byte 4 least significant. After reset or clear the expected value is 0. A mismatch sets `err_seq` and makes the received value the new expectation. The expectation rises by one at every packet end.
- R4: Each byte at position i with 8 <= i <= `PKT_LEN`-1 must equal i mod 256, otherwise `err_pay` is set.
- R5: Positions `PKT_LEN`..`PKT_LEN`+3 carry a checksum, most significant byte first. It is the reflected CRC-32 (polynomial 0x04C11DB7, reflected constant 0xEDB88320, preset all ones, result complemented) over positions 0..`PKT_LEN`-1. Any checksum byte that differs sets `err_crc`.
- R6: `in_first` must be 1 exactly at position 0, and `in_last` must be 1 exactly at position `PKT_LEN`+3. Any other combination on a taken byte sets `err_frame`.
- R7: The packet ends at the byte taken at position `PKT_LEN`+3, and the position then returns to 0. In the cycle after that byte, `fail_pulse` is 1 for one cycle if any error occurred in the packet, including on that byte; otherwise `pass_pulse` is 1. The two pulses are never both high.
- R8: `good_cnt` and `bad_cnt` rise by one, modulo 2^`CNT_W`, in the same cycle as `pass_pulse` and `fail_pulse` respectively.
- R9: Each error flag rises in the cycle after the offending byte and stays high until reset or clear.
- R10: While `clr` is 1 at a rising edge, the block returns to the reset state in the next cycle: position 0, expected sequence 0, CRC preset, flags, pulses and counters all 0.
- R11: `in_ready` is constantly 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous return to the reset state |
| in_data | input | 8 | Stream byte |
| in_first | input | 1 | Start-of-frame flag |
| in_last | input | 1 | End-of-frame flag |
| in_valid | input | 1 | Sender offers a byte |
| in_ready | output | 1 | Block accepts a byte (always 1) |
| pass_pulse | output | 1 | One-cycle pulse for a clean packet |
| fail_pulse | output | 1 | One-cycle pulse for a faulty packet |
| err_len | output | 1 | Sticky length mismatch flag |
| err_seq | output | 1 | Sticky sequence mismatch flag |
| err_pay | output | 1 | Sticky payload mismatch flag |
| err_frame | output | 1 | Sticky misplaced start/end flag |
| err_crc | output | 1 | Sticky checksum mismatch flag |
| good_cnt | output | CNT_W | Clean packet count |
| bad_cnt | output | CNT_W | Faulty packet count |

## Verification
Every result is registered once, so an error flag, a pass or fail pulse and a counter step all appear in the cycle that follows the rising edge that took the deciding byte, and a clear shows in the cycle after its edge. The bench drives one cycle at a time: it sets the inputs after a falling edge, updates its behavioural model for the rising edge that follows, and reads the outputs at the next falling edge. Every output is therefore compared exactly one register delay after its cause, on every clock, including idle cycles with junk on the data and flag inputs.

// File: rtl/pktchk_pkg.sv
`timescale 1ns/1ps
package pktchk_pkg;

  // one flag per failure kind
  typedef struct packed {
    logic len;
    logic seq;
    logic pay;
    logic frame;
    logic crc;
  } pkt_err_t;

  localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_R = 32'hEDB8_8320;

  // reflected CRC-32, one byte, LSB first
  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] din);
    logic [31:0] c;
    c = crc ^ {24'h0, din};
    for (int b = 0; b < 8; b++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_R) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pktchk_pos.sv
`timescale 1ns/1ps
module pktchk_pos #(
  parameter int unsigned LAST_IDX = 103,
  parameter int unsigned IDX_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             at_end
);

  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic             idx_en;

  assign at_end = (idx_q == IDX_W'(LAST_IDX));
  assign idx    = idx_q;
  assign idx_en = clr | adv;

  always_comb begin
    if (clr || at_end) idx_nxt = '0;
    else               idx_nxt = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_nxt;
  end

endmodule

// File: rtl/pktchk_crc32.sv
`timescale 1ns/1ps
module pktchk_crc32
  import pktchk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic        restart,
  input  logic [7:0]  din,
  output logic [31:0] crc_out
);

  logic [31:0] crc_q, crc_nxt;
  logic        crc_en;

  assign crc_en  = clr | restart | upd;
  assign crc_out = ~crc_q;

  always_comb begin
    if (clr || restart) crc_nxt = CRC_PRESET;
    else                crc_nxt = crc32_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= CRC_PRESET;
    else if (crc_en) crc_q <= crc_nxt;
  end

endmodule

// File: rtl/pktchk_fields.sv
`timescale 1ns/1ps
module pktchk_fields
  import pktchk_pkg::*;
#(
  parameter int unsigned PKT_LEN = 100,
  parameter int unsigned IDX_W   = 8
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       din,
  input  logic             sof,
  input  logic             eof,
  input  logic [23:0]      hdr_sh,
  input  logic [31:0]      exp_seq,
  input  logic [31:0]      crc_val,
  output logic [31:0]      word,
  output pkt_err_t         err
);

  localparam logic [IDX_W-1:0] LEN_I  = IDX_W'(PKT_LEN);
  localparam logic [IDX_W-1:0] LAST_I = IDX_W'(PKT_LEN + 3);

  logic [1:0]  ck;
  logic [31:0] crc_sel;
  logic        in_pay, in_sum;

  assign word    = {din, hdr_sh};
  assign in_pay  = (idx >= IDX_W'(8)) && (idx < LEN_I);
  assign in_sum  = (idx >= LEN_I);
  assign ck      = 2'(idx - LEN_I);
  assign crc_sel = crc_val << {ck, 3'b000};

  always_comb begin
    err       = '0;
    err.len   = (idx == IDX_W'(3)) && (word != 32'(PKT_LEN));
    err.seq   = (idx == IDX_W'(7)) && (word != exp_seq);
    err.pay   = in_pay && (din != idx[7:0]);
    err.crc   = in_sum && (din != crc_sel[31:24]);
    err.frame = (sof != (idx == '0)) || (eof != (idx == LAST_I));
  end

endmodule

// File: rtl/pkt_stream_checker.sv
`timescale 1ns/1ps
module pkt_stream_checker
  import pktchk_pkg::*;
#(
  parameter int unsigned PKT_LEN = 100,
  parameter int unsigned CNT_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [7:0]       in_data,
  input  logic             in_first,
  input  logic             in_last,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             pass_pulse,
  output logic             fail_pulse,
  output logic             err_len,
  output logic             err_seq,
  output logic             err_pay,
  output logic             err_frame,
  output logic             err_crc,
  output logic [CNT_W-1:0] good_cnt,
  output logic [CNT_W-1:0] bad_cnt
);

  localparam int unsigned FRAME_BYTES = PKT_LEN + 4;
  localparam int unsigned IDX_W = ($clog2(FRAME_BYTES) < 8) ? 8 : $clog2(FRAME_BYTES);

  logic             beat, at_end, end_beat;
  logic [IDX_W-1:0] idx;
  logic [31:0]      crc_val, word;
  pkt_err_t         beat_err, cur_err;

  logic [23:0]      hdr_q, hdr_nxt;
  logic [31:0]      exp_q, exp_nxt;
  logic             bad_q, bad_nxt;
  pkt_err_t         flg_q, flg_nxt;
  logic             pass_q, pass_nxt, fail_q, fail_nxt;
  logic [CNT_W-1:0] good_q, good_nxt, badc_q, badc_nxt;

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready;
  assign end_beat = beat & at_end;

  pktchk_pos #(.LAST_IDX(FRAME_BYTES - 1), .IDX_W(IDX_W)) u_pos (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(beat), .idx(idx), .at_end(at_end)
  );

  pktchk_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .upd(beat & (idx < IDX_W'(PKT_LEN))), .restart(end_beat),
    .din(in_data), .crc_out(crc_val)
  );

  pktchk_fields #(.PKT_LEN(PKT_LEN), .IDX_W(IDX_W)) u_fields (
    .idx(idx), .din(in_data), .sof(in_first), .eof(in_last),
    .hdr_sh(hdr_q), .exp_seq(exp_q), .crc_val(crc_val),
    .word(word), .err(beat_err)
  );

  always_comb begin
    cur_err  = beat ? beat_err : '0;
    hdr_nxt  = beat ? {in_data, hdr_q[23:8]} : hdr_q;
    exp_nxt  = exp_q;
    if (cur_err.seq) exp_nxt = word;          // resync on received value
    if (end_beat)    exp_nxt = exp_q + 1'b1;
    bad_nxt  = end_beat ? 1'b0 : (bad_q | (|cur_err));
    flg_nxt  = flg_q | cur_err;
    pass_nxt = end_beat & ~(bad_q | (|cur_err));
    fail_nxt = end_beat &  (bad_q | (|cur_err));
    good_nxt = good_q + CNT_W'(pass_nxt);
    badc_nxt = badc_q + CNT_W'(fail_nxt);
    if (clr) begin
      hdr_nxt  = '0;
      exp_nxt  = '0;
      bad_nxt  = 1'b0;
      flg_nxt  = '0;
      pass_nxt = 1'b0;
      fail_nxt = 1'b0;
      good_nxt = '0;
      badc_nxt = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      exp_q  <= '0;
      bad_q  <= 1'b0;
      flg_q  <= '0;
      pass_q <= 1'b0;
      fail_q <= 1'b0;
      good_q <= '0;
      badc_q <= '0;
    end else begin
      hdr_q  <= hdr_nxt;
      exp_q  <= exp_nxt;
      bad_q  <= bad_nxt;
      flg_q  <= flg_nxt;
      pass_q <= pass_nxt;
      fail_q <= fail_nxt;
      good_q <= good_nxt;
      badc_q <= badc_nxt;
    end
  end

  assign pass_pulse = pass_q;
  assign fail_pulse = fail_q;
  assign err_len    = flg_q.len;
  assign err_seq    = flg_q.seq;
  assign err_pay    = flg_q.pay;
  assign err_frame  = flg_q.frame;
  assign err_crc    = flg_q.crc;
  assign good_cnt   = good_q;
  assign bad_cnt    = badc_q;

endmodule

// File: rtl/pkt_stream_checker_sva.sv
`timescale 1ns/1ps
module pkt_stream_checker_sva #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_valid,
  input logic             in_ready,
  input logic             at_end,
  input logic             pass_pulse,
  input logic             fail_pulse,
  input logic [4:0]       flags,
  input logic [CNT_W-1:0] good_cnt,
  input logic [CNT_W-1:0] bad_cnt
);

  // R11
  rdy_const_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse && fail_pulse));

  // R7
  pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_pulse || fail_pulse) |-> $past(in_valid && at_end && !clr));

  // R8
  good_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |-> (good_cnt == CNT_W'($past(good_cnt) + 1'b1)));

  // R8
  bad_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |-> (bad_cnt == CNT_W'($past(bad_cnt) + 1'b1)));

  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !clr) |=> (!pass_pulse && !fail_pulse && $stable(good_cnt) && $stable(bad_cnt)));

  // R10
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (good_cnt == '0 && bad_cnt == '0 && flags == '0 && !pass_pulse && !fail_pulse));

endmodule

bind pkt_stream_checker pkt_stream_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_ready(in_ready),
  .at_end(at_end), .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
  .flags({err_len, err_seq, err_pay, err_frame, err_crc}),
  .good_cnt(good_cnt), .bad_cnt(bad_cnt)
);

// File: tb/test_pkt_stream_checker.sv
`timescale 1ns/1ps
module test_pkt_stream_checker;

  localparam int LEN   = 100;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_first = 1'b0, in_last = 1'b0, in_valid = 1'b0;
  logic in_ready, pass_pulse, fail_pulse;
  logic err_len, err_seq, err_pay, err_frame, err_crc;
  logic [CNT_W-1:0] good_cnt, bad_cnt;

  always #4 clk = ~clk;

  pkt_stream_checker #(.PKT_LEN(LEN), .CNT_W(CNT_W)) i_pkt_stream_checker (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_data(in_data), .in_first(in_first),
    .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .pass_pulse(pass_pulse), .fail_pulse(fail_pulse),
    .err_len(err_len), .err_seq(err_seq), .err_pay(err_pay),
    .err_frame(err_frame), .err_crc(err_crc),
    .good_cnt(good_cnt), .bad_cnt(bad_cnt)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural reference state
  int          m_idx;
  logic [31:0] m_crc, m_exp;
  logic [7:0]  m_buf [8];
  bit          m_bad, m_len, m_seq, m_pay, m_frm, m_sum, m_pass, m_fail;
  int          m_good, m_badc;

  function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r = c ^ {24'h0, d};
    for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  task automatic model_reset();
    m_idx = 0; m_crc = 32'hFFFFFFFF; m_exp = 0; m_bad = 0;
    m_len = 0; m_seq = 0; m_pay = 0; m_frm = 0; m_sum = 0;
    m_pass = 0; m_fail = 0; m_good = 0; m_badc = 0;
  endtask

  task automatic model_beat(input logic [7:0] d, input bit s, input bit e);
    bit el = 0, es = 0, ep = 0, ef = 0, ec = 0;
    logic [31:0] w, fin;
    m_pass = 0; m_fail = 0;
    if (m_idx < 8) m_buf[m_idx] = d;
    if (m_idx == 3) begin
      w = {m_buf[3], m_buf[2], m_buf[1], m_buf[0]};
      el = (w != LEN);
    end
    if (m_idx == 7) begin
      w = {m_buf[7], m_buf[6], m_buf[5], m_buf[4]};
      if (w != m_exp) begin es = 1; m_exp = w; end
    end
    if (m_idx >= 8 && m_idx < LEN) ep = (d != (m_idx % 256));
    if (m_idx >= LEN) begin
      fin = ~m_crc;
      ec = (d != 8'((fin >> (24 - 8 * (m_idx - LEN))) & 32'hFF));
    end
    ef = (s != (m_idx == 0)) || (e != (m_idx == LEN + 3));
    if (m_idx < LEN) m_crc = crc_upd(m_crc, d);
    m_len |= el; m_seq |= es; m_pay |= ep; m_frm |= ef; m_sum |= ec;
    m_bad |= (el | es | ep | ef | ec);
    if (m_idx == LEN + 3) begin
      if (m_bad) begin m_fail = 1; m_badc++; end
      else       begin m_pass = 1; m_good++; end
      m_exp = m_exp + 1; m_bad = 0; m_crc = 32'hFFFFFFFF; m_idx = 0;
    end else m_idx++;
  endtask

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic compare(input string ctx);
    chk(in_ready === 1'b1, {ctx, " R11 in_ready"}, int'(in_ready), 1);
    chk(pass_pulse === m_pass, {ctx, " R7 pass_pulse"}, int'(pass_pulse), int'(m_pass));
    chk(fail_pulse === m_fail, {ctx, " R7 fail_pulse"}, int'(fail_pulse), int'(m_fail));
    // flags are sticky (R9)
    chk(err_len === m_len, {ctx, " R2 err_len"}, int'(err_len), int'(m_len));
    chk(err_seq === m_seq, {ctx, " R3 err_seq"}, int'(err_seq), int'(m_seq));
    chk(err_pay === m_pay, {ctx, " R4 err_pay"}, int'(err_pay), int'(m_pay));
    chk(err_crc === m_sum, {ctx, " R5 err_crc"}, int'(err_crc), int'(m_sum));
    chk(err_frame === m_frm, {ctx, " R6 err_frame"}, int'(err_frame), int'(m_frm));
    chk(good_cnt === CNT_W'(m_good), {ctx, " R8 good_cnt"}, int'(good_cnt), m_good % 65536);
    chk(bad_cnt === CNT_W'(m_badc), {ctx, " R8 bad_cnt"}, int'(bad_cnt), m_badc % 65536);
  endtask

  // one clock: drive after falling edge, sample at next falling edge
  task automatic cycle(input bit v, input logic [7:0] d, input bit s, input bit e, input string ctx);
    in_valid = v; in_data = d; in_first = s; in_last = e; clr = 0;
    if (v) model_beat(d, s, e);
    else begin m_pass = 0; m_fail = 0; end
    @(posedge clk); @(negedge clk);
    compare(ctx);
  endtask

  task automatic do_clear();
    clr = 1; in_valid = 0; in_data = 8'h3C; in_first = 1; in_last = 1;
    model_reset();
    @(posedge clk); @(negedge clk);
    clr = 0;
    compare("R10 clear");
  endtask

  // kind: 0 clean, 1 length, 2 payload, 3 checksum, 4 no sof, 5 early eof
  task automatic send_pkt(input logic [31:0] seq, input int kind, input int gap, input int stop_at);
    logic [7:0] b [LEN + 4];
    bit sf [LEN + 4];
    bit ef [LEN + 4];
    logic [31:0] c;
    for (int i = 0; i < LEN; i++) begin
      if (i < 4)      b[i] = 8'(LEN >> (8 * i));
      else if (i < 8) b[i] = 8'(seq >> (8 * (i - 4)));
      else            b[i] = 8'(i);
    end
    if (kind == 1) b[0] ^= 8'h01;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < LEN; i++) c = crc_upd(c, b[i]);
    c = ~c;
    for (int k = 0; k < 4; k++) b[LEN + k] = 8'(c >> (24 - 8 * k));
    if (kind == 2) b[20] ^= 8'h40;
    if (kind == 3) b[LEN + 1] ^= 8'h01;
    for (int i = 0; i < LEN + 4; i++) begin
      sf[i] = (i == 0) && (kind != 4);
      ef[i] = (i == LEN + 3) || (kind == 5 && i == 50);
    end
    for (int i = 0; i < LEN + 4 && i < stop_at; i++) begin
      if (gap != 0 && (i % gap) == gap - 1) cycle(0, 8'hA5, 1, 1, "R1 idle");
      cycle(1, b[i], sf[i], ef[i], "beat");
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    compare("R10 reset state");
    rst_n = 1;
    @(negedge clk);
    compare("R10 after reset");

    send_pkt(0, 0, 0, 999);      // clean, back to back  (R7)
    send_pkt(1, 0, 7, 999);      // clean, with idle gaps (R1)
    send_pkt(2, 1, 0, 999);      // R2 length
    do_clear();
    send_pkt(0, 2, 5, 999);      // R4 payload (and R5)
    do_clear();
    send_pkt(0, 3, 0, 999);      // R5 checksum
    do_clear();
    send_pkt(0, 4, 0, 999);      // R6 missing start
    do_clear();
    send_pkt(0, 5, 3, 999);      // R6 early end
    do_clear();
    send_pkt(0, 0, 0, 999);
    send_pkt(1, 0, 0, 999);
    send_pkt(5, 0, 0, 999);      // R3 skipped numbers -> resync
    send_pkt(6, 0, 0, 999);      // R3 passes after resync
    send_pkt(7, 0, 11, 60);      // partial packet, then clear (R10)
    do_clear();
    send_pkt(0, 0, 0, 999);      // restart from sequence 0
    for (int i = 0; i < 5; i++) cycle(0, 8'hFF, 1, 0, "R1 idle tail");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule